// File: doc/BRIEF.md
# Hashed Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A fetch stage presents the branch address on the lookup port, together with a flag that says whether the branch target lies behind the branch. One cycle later the block returns a taken or not-taken guess. When the branch resolves, the execute stage sends the same address and the real outcome on the training port. The block folds the address into a 9-bit slot number. That slot selects one entry in a table of 512 two-bit history counters.

Each counter uses hysteresis. From a settled state it takes two opposite outcomes in a row to reverse the guess. Because of this, a loop-closing branch is mispredicted once per run of the loop, on its final pass. Each slot also has a "trained" flag, and reset clears every flag. An untrained slot is not used; the block falls back to a fixed rule instead: backward branches are guessed taken, forward branches not taken.

Top module: `branch_dir_predictor`

## Requirements
- R1: The slot number is the XOR of address bits [10:2] and bits [19:11]. Two addresses that give the same slot share one entry.
- R2: Reset clears every trained flag, so after reset every lookup follows the fixed rule. `look_vld_o` is 0 during reset.
- R3: A lookup that hits an untrained slot returns `look_taken_o` = `look_back_i` (1 = taken).
- R4: The first training write to an untrained slot marks it trained. It sets the counter to 11 if the outcome was taken and to 00 if it was not taken.
- R5: Counter codes 00 and 01 mean not taken; 10 and 11 mean taken. On a trained slot, a taken outcome adds one and stops at 11. A not-taken outcome subtracts one and stops at 00.
- R6: From a saturated counter, one opposite outcome leaves the guess unchanged and a second one in a row reverses it. As a result, a loop branch repeatedly trained as taken-taken-taken-not-taken mispredicts exactly once per loop run.
- R7: `look_vld_o` is high in the cycle after a cycle with `look_req_i` high, and low otherwise. The guess appears together with it.
- R8: If a lookup and a training write hit the same slot in one cycle, the lookup returns the slot's state from before that write.
- R9: When `train_req_i` is low, the training address and outcome change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| look_req_i | input | 1 | Lookup request |
| look_pc_i | input | 18 | Branch address bits [19:2] for lookup |
| look_back_i | input | 1 | 1 when the branch target is backward |
| look_vld_o | output | 1 | Guess valid, one cycle after a request |
| look_taken_o | output | 1 | Guess: 1 = taken |
| train_req_i | input | 1 | Training write request |
| train_pc_i | input | 18 | Branch address bits [19:2] for training |
| train_taken_i | input | 1 | Resolved outcome: 1 = taken |

## Verification
The hardest state to reach from the ports is a counter held at a limit. Without saturation, a counter that wraps from 11 to 00, or from 00 to 11, can still produce a correct-looking guess on the next lookup. To expose this, the stimulus drives a slot with repeated identical outcomes past its limit. It then applies the opposite outcome and looks up the slot after it, so that a wrapped counter gives a different guess. Aliasing between two addresses is reached by choosing one address whose low field and another whose high field give the same slot. Same-cycle lookup and training are applied to one slot so that the old value is observed.

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor #(
  parameter int IDX_W = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 look_req_i,
  input  logic [2*IDX_W+1:2]   look_pc_i,
  input  logic                 look_back_i,
  output logic                 look_vld_o,
  output logic                 look_taken_o,
  input  logic                 train_req_i,
  input  logic [2*IDX_W+1:2]   train_pc_i,
  input  logic                 train_taken_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]       ctr_q [DEPTH];
  logic [DEPTH-1:0] seen_q;
  logic [IDX_W-1:0] look_idx, train_idx;
  logic [1:0]       ctr_cur, ctr_nxt;

  function automatic logic [IDX_W-1:0] fold(input logic [2*IDX_W+1:2] pc);
    return pc[IDX_W+1:2] ^ pc[2*IDX_W+1:IDX_W+2];
  endfunction

  assign look_idx  = fold(look_pc_i);
  assign train_idx = fold(train_pc_i);
  assign ctr_cur   = ctr_q[train_idx];

  always_comb begin
    if (!seen_q[train_idx])
      ctr_nxt = train_taken_i ? 2'b11 : 2'b00;
    else if (train_taken_i)
      ctr_nxt = (ctr_cur == 2'b11) ? 2'b11 : ctr_cur + 2'b01;
    else
      ctr_nxt = (ctr_cur == 2'b00) ? 2'b00 : ctr_cur - 2'b01;
  end

  always_ff @(posedge clk_i) begin
    if (train_req_i) ctr_q[train_idx] <= ctr_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_q <= '0;
    else if (train_req_i) seen_q[train_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      look_vld_o   <= 1'b0;
      look_taken_o <= 1'b0;
    end else begin
      look_vld_o <= look_req_i;
      if (look_req_i)
        look_taken_o <= seen_q[look_idx] ? ctr_q[look_idx][1] : look_back_i;
    end
  end

  AST_LOOK_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    look_req_i |=> look_vld_o); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !look_req_i |=> !look_vld_o); // R7
  AST_STATIC_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (look_req_i && !seen_q[look_idx]) |=> (look_taken_o == $past(look_back_i))); // R3
  AST_TABLE_GUESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (look_req_i && seen_q[look_idx]) |=> (look_taken_o == $past(ctr_q[look_idx][1]))); // R5
  AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_req_i && train_taken_i && seen_q[train_idx] && ctr_cur == 2'b11)
      |=> (ctr_q[$past(train_idx)] == 2'b11)); // R5
  AST_FIRST_TRAIN_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_req_i |=> seen_q[$past(train_idx)]); // R4
  AST_NO_TRAIN_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !train_req_i |=> $stable(seen_q)); // R9
endmodule

// File: tb/test_branch_dir_predictor.sv
module test_branch_dir_predictor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic look_req = 1'b0, look_back = 1'b0, train_req = 1'b0, train_taken = 1'b0;
  logic [31:0] look_pc = '0, train_pc = '0;
  logic look_vld, look_taken;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  branch_dir_predictor i_branch_dir_predictor (
    .clk_i(clk), .rst_ni(rst_n),
    .look_req_i(look_req), .look_pc_i(look_pc[19:2]), .look_back_i(look_back),
    .look_vld_o(look_vld), .look_taken_o(look_taken),
    .train_req_i(train_req), .train_pc_i(train_pc[19:2]), .train_taken_i(train_taken)
  );

  typedef struct packed {
    logic        tr;
    logic [31:0] tpc;
    logic        tt;
    logic        lr;
    logic [31:0] lpc;
    logic        back;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] PA = 32'h0000_1000;  // slot 2
  localparam logic [31:0] PB = 32'h0000_0008;  // slot 2, alias of PA (R1)
  localparam logic [31:0] PC = 32'h0000_2000;  // slot 4
  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0, 1'b0, 1'b1, PA, 1'b1, 1'b1, 4'd3},  // R3 backward untrained
    '{1'b0, 32'h0, 1'b0, 1'b1, PA, 1'b0, 1'b0, 4'd3},  // R3 forward untrained
    '{1'b1, PA,    1'b1, 1'b1, PA, 1'b0, 1'b0, 4'd8},  // R8 old state seen
    '{1'b0, 32'h0, 1'b0, 1'b1, PA, 1'b0, 1'b1, 4'd4},  // R4 now 11
    '{1'b1, PA,    1'b0, 1'b1, PA, 1'b0, 1'b1, 4'd8},  // R8
    '{1'b0, 32'h0, 1'b0, 1'b1, PA, 1'b0, 1'b1, 4'd6},  // R6 one miss keeps taken
    '{1'b1, PA,    1'b0, 1'b1, PA, 1'b0, 1'b1, 4'd6},  // R6
    '{1'b0, 32'h0, 1'b0, 1'b1, PA, 1'b0, 1'b0, 4'd6},  // R6 second miss flips
    '{1'b1, PA,    1'b0, 1'b1, PA, 1'b0, 1'b0, 4'd5},  // R5 -> 00
    '{1'b1, PA,    1'b0, 1'b1, PA, 1'b0, 1'b0, 4'd5},  // R5 saturate low
    '{1'b1, PA,    1'b1, 1'b1, PA, 1'b0, 1'b0, 4'd5},  // R5 -> 01
    '{1'b1, PA,    1'b1, 1'b1, PA, 1'b0, 1'b0, 4'd5},  // R5 -> 10
    '{1'b0, 32'h0, 1'b0, 1'b1, PA, 1'b0, 1'b1, 4'd5},  // R5
    '{1'b0, PC,    1'b0, 1'b1, PC, 1'b1, 1'b1, 4'd9},  // R9 idle train
    '{1'b0, 32'h0, 1'b0, 1'b0, PC, 1'b0, 1'b0, 4'd7},  // R7 no request
    '{1'b0, 32'h0, 1'b0, 1'b1, PC, 1'b1, 1'b1, 4'd9},  // R9 still untrained
    '{1'b0, 32'h0, 1'b0, 1'b1, PB, 1'b0, 1'b1, 4'd1},  // R1 alias hits PA
    '{1'b1, PC,    1'b0, 1'b1, PB, 1'b0, 1'b1, 4'd4},  // R4 first NT
    '{1'b0, 32'h0, 1'b0, 1'b1, PC, 1'b1, 1'b0, 4'd4},  // R4 00 beats rule
    '{1'b1, PA,    1'b1, 1'b1, PA, 1'b0, 1'b1, 4'd5},  // R5 -> 11
    '{1'b1, PA,    1'b1, 1'b1, PA, 1'b0, 1'b1, 4'd5},  // R5 saturate high
    '{1'b1, PA,    1'b0, 1'b1, PA, 1'b0, 1'b1, 4'd5},  // R5 -> 10
    '{1'b0, 32'h0, 1'b0, 1'b1, PA, 1'b0, 1'b1, 4'd5}   // R5
  };

  task automatic step(input logic tr, input logic [31:0] tpc, input logic tt,
                      input logic lr, input logic [31:0] lpc, input logic back);
    train_req = tr; train_pc = tpc; train_taken = tt;
    look_req = lr; look_pc = lpc; look_back = back;
    @(negedge clk);
    train_req = 1'b0; look_req = 1'b0;
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int miss;
    @(negedge clk); @(negedge clk);
    check("R2 valid low in reset", look_vld, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v].tr, VEC[v].tpc, VEC[v].tt, VEC[v].lr, VEC[v].lpc, VEC[v].back);
      check($sformatf("R7 vec%0d valid", v), look_vld, VEC[v].lr);
      if (VEC[v].lr)
        check($sformatf("R%0d vec%0d guess", VEC[v].req, v), look_taken, VEC[v].exp);
    end

    // R6: loop of four passes run twice, misses on second run must be one
    for (int run = 0; run < 2; run++) begin
      miss = 0;
      for (int it = 0; it < 4; it++) begin
        step(1'b1, PA, it < 3, 1'b1, PA, 1'b0);
        if (look_taken !== (it < 3)) miss++;
      end
      if (run == 1) begin
        checks++;
        if (miss != 1) begin
          failures++;
          $display("FAIL R6 loop misses actual=%0d expected=1", miss);
        end
      end
    end

    // R2: reset forgets training, fixed rule returns
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 valid cleared", look_vld, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 32'h0, 1'b0, 1'b1, PA, 1'b0);
    check("R2 forward after reset", look_taken, 1'b0);
    step(1'b0, 32'h0, 1'b0, 1'b1, PC, 1'b1);
    check("R2 backward after reset", look_taken, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule